// File: doc/BRIEF.md
# GPIO Port with Peripheral Pin Override

This block controls one port of up to eight general-purpose pins. Software sets it up through a small synchronous register bus. There are two core registers: an output latch and a direction register. Three more registers set pad behaviour for each pin: pullup, fast slew and high drive. The pad-control registers sit in a separate address region from the core registers. The block drives output-enable, output-value and pad-control signals to the pad ring. A read of the data register returns the level at each pin.

Three kinds of peripheral can take a pin away from software.
- A timer channel claim replaces both the direction bit and the latch with the timer's own enable and value.
- A keyboard-input claim forces the pin to be an input.
- An oscillator claim covers the two oscillator pins. It disconnects every register from those pins and sets all of their pad controls to zero.

In the default build only bits 0 to 6 exist. Bit 7 is absent.

Top module: `gpio_ovr_port`

## Requirements
- R1: While reset is asserted, every register clears to zero. After reset, pad_oe, pad_out, pad_pull, pad_slew and pad_drv are all 0, so every pin is an input with no pullup, slow slew and low drive.
- R2: A write with bus_sel=1 and bus_wr=1 updates the addressed register at the clock edge. The register map is:
  - address 0: data latch
  - address 1: direction, where 1 means output
  - address 4: pullup enable
  - address 5: fast slew
  - address 6: high drive

  The read data is combinational. Addresses 1, 4, 5 and 6 read back the register value. Unmapped addresses read 0.
- R3: On a pin with no peripheral claim and direction 1, pad_oe is 1 and pad_out equals the latch bit. On any pin that is not driving, pad_out is 0.
- R4: When a pin's timer claim (tmr_en) is 1 and no keyboard or oscillator claim applies, two rules hold:
  - pad_oe equals tmr_oe, whatever the direction bit holds.
  - When tmr_oe is 1, pad_out equals tmr_out, whatever the latch bit holds.
- R5: A keyboard claim (kbi_en=1) forces pad_oe to 0. It takes priority over the direction bit and over a timer claim.
- R6: While osc_en is 1, the oscillator pins (bits 5 and 6) have pad_oe, pad_out, pad_pull, pad_slew and pad_drv all at 0, whatever any register or other claim holds.
- R7: Bit 7 is not implemented:
  - All its pad outputs stay 0.
  - It reads as 0 at every address.
  - Writes to it are ignored.
- R8: Reading address 0 gives one value per pin:
  - A pin driven by the port returns its latch bit.
  - Any other pin returns pin_in delayed through two flops, so a change on pin_in shows after the second rising edge.
- R9: A write to the data latch always takes effect, even while a peripheral holds the pin. The latched value appears on pad_out once the claim is released.
- R10: On a pin without an active oscillator claim, pad_pull, pad_slew and pad_drv equal the pullup, slew and drive register bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pin_in | input | 8 | Pin levels from the pads |
| tmr_en | input | 8 | Timer channel claims the pin |
| tmr_oe | input | 8 | Timer channel output enable |
| tmr_out | input | 8 | Timer channel output value |
| kbi_en | input | 8 | Keyboard input claims the pin |
| osc_en | input | 1 | External oscillator claims bits 5 and 6 |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output value |
| pad_pull | output | 8 | Pad pullup enable |
| pad_slew | output | 8 | Pad fast slew |
| pad_drv | output | 8 | Pad high drive |

## Verification
The assertions check the following on every cycle:
- the claim priorities on the pad outputs: keyboard forces an input, the oscillator cuts off its pins, and the timer overrides the direction bit;
- that bit 7 stays silent;
- that a data write always reaches the latch;
- that the read path lags pin_in by two clocks.

Only the bench's scenarios can show three further behaviours:
- readback of each register through the bus;
- the mixed value a data read returns when some pins are port outputs and others are inputs;
- a latched value appearing on the pin when a timer claim is released.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIR   = 3'd1;
    localparam logic [ADDR_W-1:0] A_PULL  = 3'd4;
    localparam logic [ADDR_W-1:0] A_SLEW  = 3'd5;
    localparam logic [ADDR_W-1:0] A_DRIVE = 3'd6;

    typedef struct packed {
        logic [PORT_W-1:0] dat;
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] pull;
        logic [PORT_W-1:0] slew;
        logic [PORT_W-1:0] drv;
    } port_regs_t;

    typedef struct packed {
        logic [PORT_W-1:0] meta;
        logic [PORT_W-1:0] sync;
    } sync_regs_t;
endpackage

// File: rtl/gpio_ovr_regfile.sv
module gpio_ovr_regfile
    import gpio_ovr_pkg::*;
#(
    parameter logic [PORT_W-1:0] IMPL_MASK = 8'h7F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    output port_regs_t        regs_q
);
    port_regs_t regs_d;
    logic [PORT_W-1:0] wmask;

    always_comb begin
        wmask  = wdata & IMPL_MASK;
        regs_d = regs_q;
        if (wr_en) begin
            case (addr)
                A_DATA:  regs_d.dat  = wmask;
                A_DIR:   regs_d.dir  = wmask;
                A_PULL:  regs_d.pull = wmask;
                A_SLEW:  regs_d.slew = wmask;
                A_DRIVE: regs_d.drv  = wmask;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // R1: registers are clear on the cycle after reset is seen
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (regs_q == '0));

    // R9: a data write lands in the latch regardless of any claim
    p_latch_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DATA) |=> (regs_q.dat == ($past(wdata) & IMPL_MASK)));

    // R7: unimplemented bits never hold a one
    p_unimpl_regs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs_q.dat | regs_q.dir | regs_q.pull | regs_q.slew | regs_q.drv) & ~IMPL_MASK) == '0);
endmodule

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync
    import gpio_ovr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_sync
);
    sync_regs_t s_d, s_q;

    always_comb begin
        s_d.meta = pin_in;
        s_d.sync = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pin_sync = s_q.sync;

    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // R8: the synchronized level is the pin level of two edges before
    p_sync_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (pin_sync == $past(pin_in, 2)));
endmodule

// File: rtl/gpio_ovr_pinmux.sv
module gpio_ovr_pinmux #(
    parameter bit IMPL   = 1'b1,
    parameter bit IS_OSC = 1'b0
) (
    input  logic dir,
    input  logic dat,
    input  logic pull,
    input  logic slew,
    input  logic drv,
    input  logic tmr_en,
    input  logic tmr_oe,
    input  logic tmr_out,
    input  logic kbi_en,
    input  logic osc_en,
    output logic oe,
    output logic out,
    output logic pull_o,
    output logic slew_o,
    output logic drv_o,
    output logic port_drv
);
    logic live;
    logic oe_c, out_c, pdrv_c;

    always_comb begin
        live   = IMPL && !(IS_OSC && osc_en);
        pdrv_c = 1'b0;
        if (kbi_en) begin
            oe_c  = 1'b0;
            out_c = 1'b0;
        end else if (tmr_en) begin
            oe_c  = tmr_oe;
            out_c = tmr_oe & tmr_out;
        end else begin
            oe_c   = dir;
            out_c  = dir & dat;
            pdrv_c = dir;
        end
        oe       = live & oe_c;
        out      = live & out_c;
        port_drv = live & pdrv_c;
        pull_o   = live & pull;
        slew_o   = live & slew;
        drv_o    = live & drv;
    end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
    import gpio_ovr_pkg::*;
#(
    parameter logic [PORT_W-1:0] IMPL_MASK = 8'h7F,
    parameter int                OSC_A     = 5,
    parameter int                OSC_B     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    input  logic [PORT_W-1:0] tmr_en,
    input  logic [PORT_W-1:0] tmr_oe,
    input  logic [PORT_W-1:0] tmr_out,
    input  logic [PORT_W-1:0] kbi_en,
    input  logic              osc_en,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_pull,
    output logic [PORT_W-1:0] pad_slew,
    output logic [PORT_W-1:0] pad_drv
);
    port_regs_t        regs;
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] port_drv;
    logic [PORT_W-1:0] data_view;

    gpio_ovr_regfile #(.IMPL_MASK(IMPL_MASK)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_sel & bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .regs_q(regs)
    );

    gpio_ovr_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .pin_sync(pin_sync)
    );

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        gpio_ovr_pinmux #(
            .IMPL  (IMPL_MASK[i]),
            .IS_OSC(i == OSC_A || i == OSC_B)
        ) u_mux (
            .dir     (regs.dir[i]),
            .dat     (regs.dat[i]),
            .pull    (regs.pull[i]),
            .slew    (regs.slew[i]),
            .drv     (regs.drv[i]),
            .tmr_en  (tmr_en[i]),
            .tmr_oe  (tmr_oe[i]),
            .tmr_out (tmr_out[i]),
            .kbi_en  (kbi_en[i]),
            .osc_en  (osc_en),
            .oe      (pad_oe[i]),
            .out     (pad_out[i]),
            .pull_o  (pad_pull[i]),
            .slew_o  (pad_slew[i]),
            .drv_o   (pad_drv[i]),
            .port_drv(port_drv[i])
        );

        if (i == OSC_A || i == OSC_B) begin : g_osc_chk
            // R6: oscillator claim silences every pad control on its pins
            p_osc_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
                osc_en |-> !(pad_oe[i] | pad_out[i] | pad_pull[i] | pad_slew[i] | pad_drv[i]));
        end

        if (IMPL_MASK[i]) begin : g_live_chk
            // R5: keyboard claim makes the pin an input
            p_kbi_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
                kbi_en[i] |-> !pad_oe[i]);
            // R4: timer claim decides direction when nothing outranks it
            p_timer_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (tmr_en[i] && !kbi_en[i] && !(osc_en && (i == OSC_A || i == OSC_B)))
                |-> (pad_oe[i] == tmr_oe[i]));
        end else begin : g_dead_chk
            // R7: absent bit stays silent and reads zero
            p_unimpl_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !(pad_oe[i] | pad_out[i] | pad_pull[i] | pad_slew[i] | pad_drv[i] | bus_rdata[i]));
        end
    end

    always_comb begin
        data_view = ((port_drv & regs.dat) | (~port_drv & pin_sync)) & IMPL_MASK;
        case (bus_addr)
            A_DATA:  bus_rdata = data_view;
            A_DIR:   bus_rdata = regs.dir;
            A_PULL:  bus_rdata = regs.pull;
            A_SLEW:  bus_rdata = regs.slew;
            A_DRIVE: bus_rdata = regs.drv;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/gpio_ovr_port_tb_top.sv
module gpio_ovr_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] pin_in = '0, tmr_en = '0, tmr_oe = '0, tmr_out = '0, kbi_en = '0;
    logic       osc_en = 1'b0;
    logic [7:0] pad_oe, pad_out, pad_pull, pad_slew, pad_drv;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_ovr_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .tmr_en(tmr_en), .tmr_oe(tmr_oe), .tmr_out(tmr_out),
        .kbi_en(kbi_en), .osc_en(osc_en), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pull(pad_pull), .pad_slew(pad_slew), .pad_drv(pad_drv)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // fields: req, dir, dat, tmr_en, tmr_oe, tmr_out, kbi_en, osc, exp_oe, exp_out
    typedef struct packed {
        logic [7:0] req;
        logic [7:0] dir, dat, ten, toe, tout, kbi;
        logic       osc;
        logic [7:0] eoe, eout;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VT [NV] = '{
        '{8'd3, 8'hFF, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'h7F, 8'h25}, // R3 plus R7 bit 7 masked
        '{8'd3, 8'h0F, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'h0F, 8'h0F}, // R3 inputs drive 0
        '{8'd4, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h00, 1'b0, 8'h01, 8'h01}, // R4 timer over dir
        '{8'd4, 8'hFF, 8'h00, 8'hF0, 8'h30, 8'hFF, 8'h00, 1'b0, 8'h3F, 8'h30}, // R4 timer over latch
        '{8'd5, 8'hFF, 8'hFF, 8'h04, 8'h04, 8'h04, 8'h0C, 1'b0, 8'h73, 8'h73}, // R5 kbi over timer
        '{8'd6, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h1F, 8'h1F}, // R6 osc cut
        '{8'd6, 8'h60, 8'h60, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'h60, 8'h60}, // R6 osc released
        '{8'd6, 8'hFF, 8'h55, 8'h40, 8'h40, 8'h40, 8'h00, 1'b1, 8'h1F, 8'h15}  // R6 osc over timer
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] r;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "pad_oe in reset", pad_oe, 8'h00);
        rst_n = 1'b1;
        rd(3'd1, r); check("R1", "dir after reset", r, 8'h00);
        check("R1", "pad_pull after reset", pad_pull, 8'h00);
        check("R1", "pad_drv after reset", pad_drv, 8'h00);

        // R2 readback and R10 pad controls
        wr(3'd4, 8'hFF); rd(3'd4, r); check("R2", "pullup readback", r, 8'h7F);
        wr(3'd5, 8'h3C); rd(3'd5, r); check("R2", "slew readback", r, 8'h3C);
        wr(3'd6, 8'h81); rd(3'd6, r); check("R2", "drive readback", r, 8'h01);
        rd(3'd3, r); check("R2", "unmapped read", r, 8'h00);
        check("R10", "pad_pull", pad_pull, 8'h7F);
        check("R10", "pad_slew", pad_slew, 8'h3C);
        check("R10", "pad_drv", pad_drv, 8'h01);
        @(negedge clk); osc_en = 1'b1;
        #1 check("R6", "pad_pull osc", pad_pull, 8'h1F);
        check("R6", "pad_slew osc", pad_slew, 8'h1C);
        osc_en = 1'b0;

        // vector table
        for (int v = 0; v < NV; v++) begin
            wr(3'd1, VT[v].dir);
            wr(3'd0, VT[v].dat);
            @(negedge clk);
            tmr_en = VT[v].ten; tmr_oe = VT[v].toe; tmr_out = VT[v].tout;
            kbi_en = VT[v].kbi; osc_en = VT[v].osc;
            #1;
            check($sformatf("R%0d", VT[v].req), $sformatf("vec %0d pad_oe", v), pad_oe, VT[v].eoe);
            check($sformatf("R%0d", VT[v].req), $sformatf("vec %0d pad_out", v), pad_out, VT[v].eout);
        end
        @(negedge clk);
        tmr_en = '0; tmr_oe = '0; tmr_out = '0; kbi_en = '0; osc_en = 1'b0;

        // R8: mixed data read and two-flop latency
        wr(3'd1, 8'h0F);
        wr(3'd0, 8'hAA);
        @(negedge clk); pin_in = 8'hFF;
        @(negedge clk); #1 bus_addr = 3'd0; #1 check("R8", "read after one edge", bus_rdata, 8'h0A);
        @(negedge clk); #1 check("R8", "read after two edges", bus_rdata, 8'h7A);

        // R7: bit 7 ignored
        wr(3'd1, 8'hFF);
        rd(3'd1, r); check("R7", "dir bit7 write ignored", r, 8'h7F);
        check("R7", "pad_oe bit7", pad_oe & 8'h80, 8'h00);
        rd(3'd0, r); check("R7", "data bit7 reads zero", r & 8'h80, 8'h00);

        // R9: latch written under a timer claim applies on release
        wr(3'd0, 8'h00);
        @(negedge clk); tmr_en = 8'h01; tmr_oe = 8'h01; tmr_out = 8'h00;
        wr(3'd0, 8'h01);
        #1 check("R9", "timer still owns pin", pad_out & 8'h01, 8'h00);
        @(negedge clk); tmr_en = 8'h00; tmr_oe = 8'h00;
        #1 check("R9", "latch applies on release", pad_out & 8'h01, 8'h01);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule